// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Controller

This block turns a single PWM command into two gate commands for a synchronous buck stage. One goes to the high-side switch and one to the low-side switch. The two commands are never high together. Dead time is not a fixed count. It comes from two comparator flags supplied from outside the block:

- one flag reports that the low-side gate voltage has fallen below its threshold;
- the other reports that the phase node has fallen below its threshold.

A timeout forces the low-side switch on when the phase node stays high, for example while the converter sinks current. Minimum pulse rules keep very short PWM pulses from causing ringing:

- once the high-side gate is on, it stays on for a minimum on-time;
- once the low-side gate is off, it stays off for a minimum off-time.

All times are parameters in clock cycles. The PWM input and both flags pass through synchronizers before use. Enable and supply-good act directly on the state register. The block has no data stream, so there is no valid/ready handshake. Every pin is a plain level.

Top module: `gate_nonoverlap_ctrl`

## Requirements
- R1: A change on `pwm_in` or on either comparator flag takes effect on the outputs 3 rising edges after it is applied (two synchronizer flops plus the state register). On a PWM rise, `bot_gate` drops first. `top_gate` rises only after `bgate_low` has been seen high and then a further `TOP_DELAY` cycles have passed.
- R2: On a PWM fall, `top_gate` drops first. `bot_gate` rises once `phase_low` is seen high, counted from the drop of `top_gate`.
- R3: If `phase_low` stays low, `bot_gate` rises exactly `BOT_TIMEOUT` cycles after `top_gate` dropped.
- R4: Once `top_gate` rises, it stays high for at least `TOP_MIN_ON` cycles, even if the PWM command has already fallen.
- R5: Once `bot_gate` drops in normal operation, it stays low for at least `BOT_MIN_OFF` cycles, even when the phase flag is already high.
- R6: A PWM pulse that ends before `bgate_low` is seen never raises `top_gate`. `bot_gate` returns when the minimum off-time has elapsed.
- R7: `enable` low forces both outputs low at the next edge, overriding any pending timer. When `enable` returns high, the controller restarts from the current synchronized PWM level.
- R8: `supply_ok` low forces both outputs low at the next edge, and PWM activity is ignored while it stays low. Operation resumes only once `supply_ok` and `enable` are both high.
- R9: `top_gate` and `bot_gate` are never high in the same cycle.
- R10: During reset both outputs are low. At the first edge after reset, with the block enabled and PWM low, `bot_gate` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | PWM command; high requests the high-side switch |
| enable | input | 1 | Run enable; low forces both gates off |
| supply_ok | input | 1 | Supply above lockout threshold; low forces both gates off |
| bgate_low | input | 1 | Comparator flag: low-side gate voltage below its threshold |
| phase_low | input | 1 | Comparator flag: phase node below its threshold |
| top_gate | output | 1 | High-side gate command |
| bot_gate | output | 1 | Low-side gate command |

## Verification
Each output change is due at a fixed cycle, reckoned from the cycle in which the bench drove the stimulus. A PWM or flag change adds three cycles of latency. Each counted phase then adds its full length: the top-gate delay, the minimum on-time, the minimum off-time (measured from the drop of the low-side gate) or the timeout (measured from the drop of the high-side gate). An enable or supply change lands one cycle later. The bench computes these cycle numbers when it applies the stimulus and queues them. A monitor compares every actual output change against the queue, cycle for cycle, so a change that is early, late or unexpected is reported.

// File: rtl/gnc_pkg.sv
package gnc_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Controller phases; only ST_BOT_ON and ST_TOP_ON drive a gate.
  typedef enum logic [2:0] {
    ST_OFF,
    ST_BOT_ON,
    ST_WAIT_BG_LOW,
    ST_TOP_DELAY,
    ST_TOP_ON,
    ST_WAIT_PH_LOW
  } gnc_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/gnc_sync.sv
module gnc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gnc_timer.sv
module gnc_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/gate_nonoverlap_ctrl.sv
module gate_nonoverlap_ctrl
  import gnc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TOP_MIN_ON  = 4,
  parameter int BOT_MIN_OFF = 14,
  parameter int BOT_TIMEOUT = 18,
  parameter int TOP_DELAY   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic enable,
  input  logic supply_ok,
  input  logic bgate_low,
  input  logic phase_low,
  output logic top_gate,
  output logic bot_gate
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TMAX  = max3(TOP_MIN_ON, BOT_MIN_OFF, max3(BOT_TIMEOUT, TOP_DELAY, 1));
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam logic [CNT_W-1:0] LD_TON = CNT_W'(TOP_MIN_ON - 1);
  localparam logic [CNT_W-1:0] LD_OFF = CNT_W'(BOT_MIN_OFF - 1);
  localparam logic [CNT_W-1:0] LD_TO  = CNT_W'(BOT_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] LD_DLY = CNT_W'(TOP_DELAY - 1);

  // Synchronized copies of the asynchronous inputs.
  logic [2:0] sync_q;
  logic       pwm_s, bgl_s, phl_s;

  gnc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pwm_in, bgate_low, phase_low}),
    .q     (sync_q)
  );
  assign {pwm_s, bgl_s, phl_s} = sync_q;

  gnc_state_e       state, nxt;
  logic             run;
  logic             off_ld, off_done;
  logic             step_ld, step_done;
  logic [CNT_W-1:0] step_val;

  // Bottom-gate minimum off-time, started whenever the bottom gate is released.
  gnc_timer #(.W(CNT_W)) u_off_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (off_ld),
    .load_val (LD_OFF),
    .done     (off_done)
  );

  // Shared timer: top delay, top minimum on-time, bottom-on timeout.
  gnc_timer #(.W(CNT_W)) u_step_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (step_ld),
    .load_val (step_val),
    .done     (step_done)
  );

  assign run = enable && supply_ok;

  always_comb begin
    nxt      = state;
    off_ld   = 1'b0;
    step_ld  = 1'b0;
    step_val = '0;
    if (!run) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (pwm_s) begin
            nxt    = ST_WAIT_BG_LOW;
            off_ld = 1'b1;
          end else begin
            nxt = ST_BOT_ON;
          end
        end
        ST_BOT_ON: begin
          if (pwm_s) begin
            nxt    = ST_WAIT_BG_LOW;
            off_ld = 1'b1;
          end
        end
        ST_WAIT_BG_LOW: begin
          if (!pwm_s) begin
            nxt      = ST_WAIT_PH_LOW;
            step_ld  = 1'b1;
            step_val = LD_TO;
          end else if (bgl_s) begin
            nxt      = ST_TOP_DELAY;
            step_ld  = 1'b1;
            step_val = LD_DLY;
          end
        end
        ST_TOP_DELAY: begin
          if (!pwm_s) begin
            nxt      = ST_WAIT_PH_LOW;
            step_ld  = 1'b1;
            step_val = LD_TO;
          end else if (step_done) begin
            nxt      = ST_TOP_ON;
            step_ld  = 1'b1;
            step_val = LD_TON;
          end
        end
        ST_TOP_ON: begin
          if (!pwm_s && step_done) begin
            nxt      = ST_WAIT_PH_LOW;
            step_ld  = 1'b1;
            step_val = LD_TO;
          end
        end
        ST_WAIT_PH_LOW: begin
          if (off_done && (phl_s || step_done)) nxt = ST_BOT_ON;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assign top_gate = (state == ST_TOP_ON);
  assign bot_gate = (state == ST_BOT_ON);

  // Pulse-length trackers used only by the assertions below.
  logic [CNT_W:0] on_len, off_len;
  localparam logic [CNT_W:0] SAT = {(CNT_W+1){1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_len  <= '0;
      off_len <= '0;
    end else begin
      on_len  <= top_gate  ? ((on_len  == SAT) ? SAT : on_len  + 1'b1) : '0;
      off_len <= !bot_gate ? ((off_len == SAT) ? SAT : off_len + 1'b1) : '0;
    end
  end

  // R9: gates never overlap
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_gate && bot_gate));

  // R7: enable low releases both gates at the next edge
  p_enable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!top_gate && !bot_gate));

  // R8: supply loss releases both gates at the next edge
  p_supply_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!top_gate && !bot_gate));

  // R4: top gate honours its minimum on-time unless shut down
  p_top_min_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(top_gate) && $past(run)) |-> (on_len >= (CNT_W+1)'(TOP_MIN_ON)));

  // R5: bottom gate honours its minimum off-time after a normal release
  p_bot_min_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bot_gate) && $past(state != ST_OFF)) |-> (off_len >= (CNT_W+1)'(BOT_MIN_OFF)));
endmodule

// File: tb/gate_nonoverlap_ctrl_bench.sv
module gate_nonoverlap_ctrl_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TON  = 4;
  localparam int TOFF = 14;
  localparam int TTO  = 18;
  localparam int TDLY = 2;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, enable = 1'b1, supply_ok = 1'b1;
  logic bgate_low = 1'b0, phase_low = 1'b0;
  logic top_gate, bot_gate;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int        q_at[$];
  logic [1:0] q_tb[$];
  string     q_tag[$];

  gate_nonoverlap_ctrl #(
    .SYNC_STAGES(2), .TOP_MIN_ON(TON), .BOT_MIN_OFF(TOFF),
    .BOT_TIMEOUT(TTO), .TOP_DELAY(TDLY)
  ) u_gate_nonoverlap_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .enable(enable),
    .supply_ok(supply_ok), .bgate_low(bgate_low), .phase_low(phase_low),
    .top_gate(top_gate), .bot_gate(bot_gate)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int at, input logic t, input logic b, input string tag);
    q_at.push_back(at);
    q_tb.push_back({t, b});
    q_tag.push_back(tag);
  endtask

  task automatic go_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: every output change must match the next queued expectation.
  logic [1:0] prev = 2'b00;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ({top_gate, bot_gate} != prev)) begin
        checks++;
        if (top_gate && bot_gate) begin
          fails++;
          $display("FAIL R9: overlap at cycle %0d actual tg=%b bg=%b expected not both",
                   cyc, top_gate, bot_gate);
        end else if (q_at.size() == 0) begin
          fails++;
          $display("FAIL unexpected change at cycle %0d actual tg=%b bg=%b expected no change",
                   cyc, top_gate, bot_gate);
        end else begin
          int a; logic [1:0] v; string tg;
          a = q_at.pop_front(); v = q_tb.pop_front(); tg = q_tag.pop_front();
          if (a != cyc || v != {top_gate, bot_gate}) begin
            fails++;
            $display("FAIL %s: actual cycle %0d tg/bg=%b expected cycle %0d tg/bg=%b",
                     tg, cyc, {top_gate, bot_gate}, a, v);
          end
        end
        prev = {top_gate, bot_gate};
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual still running at cycle %0d expected finish earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int c, f, t, g;
    // R10: reset state
    repeat (4) @(negedge clk);
    checks++;
    if (top_gate || bot_gate) begin
      fails++;
      $display("FAIL R10: in reset actual tg=%b bg=%b expected 0 0", top_gate, bot_gate);
    end
    c = cyc;
    push(c + 1, 0, 1, "R10");
    rst_n = 1'b1;
    go_to(c + 10);

    // R1, R2: normal pulse with both flags
    c = cyc;
    push(c + LAT, 0, 0, "R1");
    push(c + 3 + LAT + TDLY, 1, 0, "R1");
    pwm_in = 1'b1;
    go_to(c + 3); bgate_low = 1'b1;
    f = c + 20;
    push(f + LAT, 0, 0, "R2");
    push(f + 5 + LAT, 0, 1, "R2");
    go_to(f); pwm_in = 1'b0; bgate_low = 1'b0;
    go_to(f + 5); phase_low = 1'b1;
    go_to(f + 12); phase_low = 1'b0;
    go_to(f + 30);

    // R3: phase flag never arrives
    c = cyc;
    push(c + LAT, 0, 0, "R1");
    push(c + 1 + LAT + TDLY, 1, 0, "R1");
    pwm_in = 1'b1; bgate_low = 1'b1;
    f = c + 20;
    push(f + LAT, 0, 0, "R2");
    push(f + LAT + TTO, 0, 1, "R3");
    go_to(f); pwm_in = 1'b0; bgate_low = 1'b0;
    go_to(f + LAT + TTO + 10);

    // R4, R5: short pulse after top turned on
    c = cyc;
    push(c + LAT, 0, 0, "R1");
    push(c + 1 + LAT + TDLY, 1, 0, "R1");
    push(c + 1 + LAT + TDLY + TON, 0, 0, "R4");
    push(c + LAT + TOFF, 0, 1, "R5");
    pwm_in = 1'b1; bgate_low = 1'b1; phase_low = 1'b1;
    go_to(c + 4); pwm_in = 1'b0;
    go_to(c + 25); bgate_low = 1'b0; phase_low = 1'b0;
    go_to(c + 35);

    // R6: pulse ends before low-gate flag is seen
    c = cyc;
    push(c + LAT, 0, 0, "R6");
    push(c + LAT + TOFF, 0, 1, "R6");
    pwm_in = 1'b1; phase_low = 1'b1;
    go_to(c + 2); pwm_in = 1'b0;
    go_to(c + 25); phase_low = 1'b0;
    go_to(c + 30);

    // R7: enable drop overrides minimum on-time, then restart
    c = cyc;
    t = c + 1 + LAT + TDLY;
    push(c + LAT, 0, 0, "R1");
    push(t, 1, 0, "R1");
    push(t + 1, 0, 0, "R7");
    push(t + 7 + TDLY, 1, 0, "R7");
    pwm_in = 1'b1; bgate_low = 1'b1;
    go_to(t); enable = 1'b0;
    go_to(t + 5); enable = 1'b1;
    g = t + 7 + TDLY + 10;
    push(g + 1, 0, 0, "R7");
    push(g + 5, 0, 1, "R7");
    go_to(g); enable = 1'b0; pwm_in = 1'b0; bgate_low = 1'b0;
    go_to(g + 4); enable = 1'b1;
    go_to(g + 15);

    // R8: supply loss holds gates off and ignores PWM
    c = cyc;
    push(c + 1, 0, 0, "R8");
    push(c + 13, 0, 1, "R8");
    supply_ok = 1'b0;
    go_to(c + 2); pwm_in = 1'b1;
    go_to(c + 6); pwm_in = 1'b0;
    go_to(c + 12); supply_ok = 1'b1;
    go_to(c + 30);

    checks++;
    if (q_at.size() != 0) begin
      fails++;
      $display("FAIL %s: actual %0d expectations left expected 0", q_tag[0], q_at.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule